// File: doc/BRIEF.md
# Strap-Addressed I2C Register Target

This block is an I2C target that holds a small register file and answers to one 7-bit bus address. Two strap pins choose that address. Three of the four strap codes each select a fixed address. The fourth strap code switches the bus function off completely, so the block never pulls SDA low. The straps are captured while reset is asserted. Changes to them after reset have no effect until the next reset.

A host reaches the registers in two ways:
- **Setting the pointer and writing:** the host addresses the target for writing and sends one byte, which becomes the register pointer. Any further bytes in the same write are stored at the pointer, and the pointer advances after each one.
- **Reading:** the host addresses the target for reading and clocks out as many bytes as it likes. Each byte comes from the current pointer, and the pointer advances once per byte.

The pointer wraps from the last register back to register 0. It is kept across a repeated START, so the usual access is: write the pointer, send a repeated START, then read.

SCL and SDA arrive already synchronised to the system clock. The block drives SDA only through an open-drain pull-down enable.

Top module: `i2cs_strap_target`

## Requirements
- R1: The strap code selects the address, with A1 and A0 taken as a pair. A1=1, A0=1 gives 0x75. A1=1, A0=0 gives 0x11. A1=0, A0=1 gives 0x07. When the first 7 bits after a START equal the selected address, the target ACKs the address byte.
- R2: During every ACK it gives, the target pulls SDA low from the SCL falling edge after the 8th bit until the SCL falling edge after the 9th bit. This applies to the address byte and to each written data byte.
- R3: When the address does not match, the target leaves SDA released through the ACK bit and through the rest of the transfer. Bytes written after a non-matching address change no register.
- R4: With A1=0 and A0=0 the target never pulls SDA low, whatever address is sent.
- R5: The straps are sampled only while rst is high. A strap change after reset leaves the active address unchanged.
- R6: In a write transfer, the first data byte loads the pointer from its low log2(NUM_REGS) bits. Each later data byte is stored in the register at the pointer, and then the pointer advances by one.
- R7: In a read transfer, each byte is the register at the pointer, sent MSB first, and the pointer advances by one after each byte. A host ACK (SDA low on the 9th clock) makes the target send the next byte.
- R8: The pointer steps from NUM_REGS-1 to 0, both when reading and when writing.
- R9: A host NACK (SDA high on the 9th clock of a read byte) ends the read. The target keeps SDA released for any further clocks until the next START or STOP.
- R10: A repeated START keeps the pointer value.
- R11: Reset releases SDA, clears the pointer to 0, and sets register i to 0x40+i.
- R12: A STOP returns the target to idle with SDA released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; the straps are sampled while it is high |
| scl_i | input | 1 | Bus clock, already synchronised to clk |
| sda_i | input | 1 | Bus data line level, already synchronised to clk |
| strap_a0 | input | 1 | Address strap A0 |
| strap_a1 | input | 1 | Address strap A1 |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The assertions rely on the following conditions on the inputs:
- The bus is legal: SDA changes only while SCL is low, except when the host makes a START or STOP.
- Each SCL level lasts several system clocks.
- The straps are stable while reset is high.

Under these conditions, the SDA enable can only change just after SCL has been sampled low, and a START or STOP cannot arrive while the target is holding SDA down.

The bench respects all of this. It models a host with a wired-AND line, changes SCL and SDA only on falling clock edges, and holds each quarter of an SCL bit for eight system clocks. It changes the straps only inside a reset pulse, except in the one test that moves them on purpose to show they are ignored.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
    timeunit 1ns;
    timeprecision 100ps;

    localparam logic [6:0] ADDR_BOTH = 7'h75;
    localparam logic [6:0] ADDR_A1   = 7'h11;
    localparam logic [6:0] ADDR_A0   = 7'h07;

    typedef struct packed {
        logic       en;
        logic [6:0] addr;
    } strap_cfg_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_ev_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WR,
        ST_WACK,
        ST_RD,
        ST_RACK,
        ST_RNEXT,
        ST_HOLD
    } tgt_state_t;

    function automatic strap_cfg_t decode_strap(input logic a1, input logic a0);
        strap_cfg_t c;
        c.en = 1'b1;
        case ({a1, a0})
            2'b11:   c.addr = ADDR_BOTH;
            2'b10:   c.addr = ADDR_A1;
            2'b01:   c.addr = ADDR_A0;
            default: begin
                c.en   = 1'b0;
                c.addr = '0;
            end
        endcase
        return c;
    endfunction

    function automatic logic [7:0] reg_init(input int idx);
        return 8'h40 + idx[7:0];
    endfunction
endpackage

// File: rtl/i2cs_bus_events.sv
module i2cs_bus_events
    import i2cs_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    timeunit 1ns;
    timeprecision 100ps;

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    // SDA moving while SCL stays high marks START or STOP
    always_comb begin
        ev.start = scl_i && scl_q && sda_q && !sda_i;
        ev.stop  = scl_i && scl_q && !sda_q && sda_i;
        ev.rise  = scl_i && !scl_q;
        ev.fall  = !scl_i && scl_q;
    end
endmodule

// File: rtl/i2cs_regfile.sv
module i2cs_regfile
    import i2cs_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    timeunit 1ns;
    timeprecision 100ps;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= reg_init(i);
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/i2cs_strap_target.sv
module i2cs_strap_target
    import i2cs_pkg::*;
#(
    parameter int NUM_REGS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    input  logic strap_a0,
    input  logic strap_a1,
    output logic sda_oe
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam int PTR_W = $clog2(NUM_REGS);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(NUM_REGS - 1);

    bus_ev_t          ev;
    strap_cfg_t       cfg_q;
    tgt_state_t       state;
    logic [3:0]       bit_cnt;
    logic [6:0]       shreg;
    logic [7:0]       rx_byte;
    logic [7:0]       tx_q;
    logic [PTR_W-1:0] ptr;
    logic [PTR_W-1:0] ptr_next;
    logic             need_ptr;
    logic             rnw;
    logic             reg_we;
    logic [7:0]       rd_data;

    i2cs_bus_events u_events (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2cs_regfile #(.DEPTH(NUM_REGS)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (reg_we),
        .waddr (ptr),
        .wdata (rx_byte),
        .raddr (ptr),
        .rdata (rd_data)
    );

    assign rx_byte  = {shreg, sda_i};
    assign ptr_next = (ptr == PTR_LAST) ? '0 : ptr + PTR_W'(1);
    assign reg_we   = (state == ST_WR) && ev.rise && (bit_cnt == 4'd7) && !need_ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= decode_strap(strap_a1, strap_a0);
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            shreg    <= '0;
            tx_q     <= '0;
            ptr      <= '0;
            need_ptr <= 1'b0;
            rnw      <= 1'b0;
            sda_oe   <= 1'b0;
        end else if (ev.stop) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
        end else if (ev.start) begin
            state   <= cfg_q.en ? ST_ADDR : ST_IDLE;
            bit_cnt <= '0;
            sda_oe  <= 1'b0;
        end else begin
            case (state)
                ST_ADDR: if (ev.rise) begin
                    shreg   <= rx_byte[6:0];
                    bit_cnt <= bit_cnt + 4'd1;
                    if (bit_cnt == 4'd7) begin
                        bit_cnt <= '0;
                        if (rx_byte[7:1] == cfg_q.addr) begin
                            state <= ST_AACK;
                            rnw   <= rx_byte[0];
                        end else begin
                            state <= ST_HOLD;
                        end
                    end
                end
                // first falling edge pulls SDA, second one ends the ACK bit
                ST_AACK: if (ev.fall) begin
                    if (!sda_oe) begin
                        sda_oe <= 1'b1;
                    end else if (rnw) begin
                        state   <= ST_RD;
                        tx_q    <= rd_data;
                        sda_oe  <= ~rd_data[7];
                        bit_cnt <= '0;
                    end else begin
                        state    <= ST_WR;
                        sda_oe   <= 1'b0;
                        need_ptr <= 1'b1;
                    end
                end
                ST_WR: if (ev.rise) begin
                    shreg   <= rx_byte[6:0];
                    bit_cnt <= bit_cnt + 4'd1;
                    if (bit_cnt == 4'd7) begin
                        bit_cnt <= '0;
                        state   <= ST_WACK;
                        if (need_ptr) begin
                            ptr      <= rx_byte[PTR_W-1:0];
                            need_ptr <= 1'b0;
                        end else begin
                            ptr <= ptr_next;
                        end
                    end
                end
                ST_WACK: if (ev.fall) begin
                    if (!sda_oe) begin
                        sda_oe <= 1'b1;
                    end else begin
                        sda_oe <= 1'b0;
                        state  <= ST_WR;
                    end
                end
                ST_RD: begin
                    if (ev.rise) begin
                        bit_cnt <= bit_cnt + 4'd1;
                    end else if (ev.fall) begin
                        if (bit_cnt == 4'd8) begin
                            sda_oe  <= 1'b0;
                            ptr     <= ptr_next;
                            bit_cnt <= '0;
                            state   <= ST_RACK;
                        end else begin
                            sda_oe <= ~tx_q[3'd7 - bit_cnt[2:0]];
                        end
                    end
                end
                ST_RACK: if (ev.rise) begin
                    state <= sda_i ? ST_HOLD : ST_RNEXT;
                end
                ST_RNEXT: if (ev.fall) begin
                    tx_q   <= rd_data;
                    sda_oe <= ~rd_data[7];
                    state  <= ST_RD;
                end
                default: ;
            endcase
        end
    end

    // R4: with the bus function strapped off, SDA is never pulled
    p_off_never_drives_r4: assert property (@(posedge clk) disable iff (rst)
        !cfg_q.en |-> !sda_oe);

    // R1: the address-ACK phase is reached only with an enabled strap code
    p_ack_needs_enable_r1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_AACK) |-> cfg_q.en);

    // R2: SDA drive changes only after SCL was seen low
    p_sda_moves_scl_low_r2: assert property (@(posedge clk) disable iff (rst)
        (sda_oe != $past(sda_oe)) |-> !$past(scl_i));

    // R12: a STOP leaves SDA released
    p_stop_releases_r12: assert property (@(posedge clk) disable iff (rst)
        $past(ev.stop) |-> !sda_oe);

    // R9: while waiting for START/STOP the target stays off the line
    p_hold_silent_r9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD) |-> !sda_oe);
endmodule

// File: tb/tb_i2cs_strap_target.sv
module tb_i2cs_strap_target;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic strap_a0 = 1'b1;
    logic strap_a1 = 1'b1;
    logic sda_oe;
    logic sda_line;

    int checks = 0;
    int errors = 0;
    int oe_cnt = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    always @(posedge clk) if (sda_oe) oe_cnt <= oe_cnt + 1;

    i2cs_strap_target dut (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (scl),
        .sda_i    (sda_line),
        .strap_a0 (strap_a0),
        .strap_a1 (strap_a1),
        .sda_oe   (sda_oe)
    );

    // {strap A1,A0, 7-bit address, expected ACK}
    localparam logic [9:0] VEC [10] = '{
        {2'b11, 7'h75, 1'b1},
        {2'b11, 7'h11, 1'b0},
        {2'b10, 7'h11, 1'b1},
        {2'b10, 7'h07, 1'b0},
        {2'b01, 7'h07, 1'b1},
        {2'b01, 7'h75, 1'b0},
        {2'b00, 7'h00, 1'b0},
        {2'b00, 7'h75, 1'b0},
        {2'b00, 7'h11, 1'b0},
        {2'b00, 7'h07, 1'b0}
    };

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic apply_reset(input logic [1:0] s);
        @(negedge clk);
        {strap_a1, strap_a0} = s;
        scl = 1'b1;
        sda_m = 1'b1;
        rst = 1'b1;
        wait_n(4);
        rst = 1'b0;
        wait_n(4);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl = 1'b1; wait_n(Q);
        sda_m = 1'b0; wait_n(Q);
        scl = 1'b0; wait_n(Q);
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; wait_n(Q);
        scl = 1'b1; wait_n(Q);
        sda_m = 1'b0; wait_n(Q);
        scl = 1'b0; wait_n(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_n(Q);
        scl = 1'b1; wait_n(Q);
        sda_m = 1'b1; wait_n(Q);
    endtask

    task automatic wr_bit(input logic b);
        sda_m = b; wait_n(Q);
        scl = 1'b1; wait_n(Q);
        scl = 1'b0; wait_n(Q);
    endtask

    task automatic rd_bit(output logic b);
        sda_m = 1'b1; wait_n(Q);
        scl = 1'b1; wait_n(Q / 2);
        b = sda_line; wait_n(Q / 2);
        scl = 1'b0; wait_n(Q);
    endtask

    task automatic wr_byte(input logic [7:0] d, output logic ack);
        logic x;
        for (int i = 7; i >= 0; i--) wr_bit(d[i]);
        rd_bit(x);
        ack = ~x;
    endtask

    task automatic rd_byte(output logic [7:0] d, input logic mack);
        logic x;
        for (int i = 7; i >= 0; i--) begin
            rd_bit(x);
            d[i] = x;
        end
        wr_bit(mack ? 1'b0 : 1'b1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog all requirements actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic       ack;
        logic [7:0] d;
        int         oe_before;

        // address table: R1 match, R3 mismatch, R4 strapped off
        for (int i = 0; i < 10; i++) begin
            apply_reset(VEC[i][9:8]);
            oe_before = oe_cnt;
            bus_start();
            wr_byte({VEC[i][7:1], 1'b0}, ack);
            bus_stop();
            if (VEC[i][9:8] == 2'b00) begin
                check("R4 ack", {7'd0, ack}, 8'd0);
                check("R4 no drive", 8'(oe_cnt - oe_before), 8'd0);
            end else if (VEC[i][0]) begin
                check("R1 address ack", {7'd0, ack}, 8'd1);
            end else begin
                check("R3 mismatch nack", {7'd0, ack}, 8'd0);
            end
        end

        // R11 reset state and R7 sequential read from pointer 0
        apply_reset(2'b11);
        check("R11 sda released", {7'd0, sda_oe}, 8'd0);
        bus_start();
        wr_byte(8'hEB, ack);
        check("R2 read address ack", {7'd0, ack}, 8'd1);
        rd_byte(d, 1'b1); check("R11 R7 reg0", d, 8'h40);
        rd_byte(d, 1'b1); check("R7 reg1", d, 8'h41);
        rd_byte(d, 1'b0); check("R7 reg2", d, 8'h42);
        bus_stop();

        // R6 pointer load and writes, R10 pointer kept over repeated START, R8 wrap
        bus_start();
        wr_byte(8'hEA, ack);
        wr_byte(8'h05, ack); check("R2 pointer byte ack", {7'd0, ack}, 8'd1);
        wr_byte(8'hA5, ack); check("R2 data ack", {7'd0, ack}, 8'd1);
        wr_byte(8'h3C, ack); check("R6 data ack", {7'd0, ack}, 8'd1);
        bus_rstart();
        wr_byte(8'hEB, ack);
        rd_byte(d, 1'b1); check("R10 pointer kept reg7", d, 8'h47);
        rd_byte(d, 1'b0); check("R8 read wrap reg0", d, 8'h40);
        oe_before = oe_cnt;
        rd_byte(d, 1'b0); check("R9 released after nack", d, 8'hFF);
        check("R9 no drive", 8'(oe_cnt - oe_before), 8'd0);
        bus_stop();

        bus_start();
        wr_byte(8'hEA, ack);
        wr_byte(8'h05, ack);
        bus_rstart();
        wr_byte(8'hEB, ack);
        rd_byte(d, 1'b1); check("R6 reg5 written", d, 8'hA5);
        rd_byte(d, 1'b0); check("R6 reg6 written", d, 8'h3C);
        bus_stop();
        check("R12 released after stop", {7'd0, sda_oe}, 8'd0);

        // R8 write wrap: 0x11 to reg7, 0x22 to reg0, pointer ends at 1
        bus_start();
        wr_byte(8'hEA, ack);
        wr_byte(8'h07, ack);
        wr_byte(8'h11, ack);
        wr_byte(8'h22, ack);
        bus_stop();
        bus_start();
        wr_byte(8'hEB, ack);
        rd_byte(d, 1'b1); check("R8 pointer wrapped to 1", d, 8'h41);
        rd_byte(d, 1'b0); check("R7 reg2", d, 8'h42);
        bus_stop();
        bus_start();
        wr_byte(8'hEA, ack);
        wr_byte(8'h07, ack);
        bus_rstart();
        wr_byte(8'hEB, ack);
        rd_byte(d, 1'b1); check("R8 reg7 written", d, 8'h11);
        rd_byte(d, 1'b0); check("R8 reg0 written", d, 8'h22);
        bus_stop();

        // R3 writes to another address leave registers alone
        bus_start();
        wr_byte(8'h22, ack); check("R3 foreign address nack", {7'd0, ack}, 8'd0);
        wr_byte(8'h02, ack); check("R3 foreign data nack", {7'd0, ack}, 8'd0);
        wr_byte(8'h99, ack);
        bus_stop();
        bus_start();
        wr_byte(8'hEA, ack);
        wr_byte(8'h02, ack);
        bus_rstart();
        wr_byte(8'hEB, ack);
        rd_byte(d, 1'b0); check("R3 reg2 unchanged", d, 8'h42);
        bus_stop();

        // R5 strap changes after reset are ignored
        apply_reset(2'b11);
        {strap_a1, strap_a0} = 2'b00;
        bus_start();
        wr_byte(8'hEA, ack); check("R5 still 0x75 after strap off", {7'd0, ack}, 8'd1);
        bus_stop();
        {strap_a1, strap_a0} = 2'b10;
        bus_start();
        wr_byte(8'h22, ack); check("R5 0x11 not adopted", {7'd0, ack}, 8'd0);
        bus_stop();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule